// File: doc/BRIEF.md
# Store Queue with Exact-Match Load Forwarding

This block sits between a load/store unit and the write port of a level-one data cache. Stores of 1, 2, 4 or 8 bytes enter an in-order queue and are written to the cache oldest first, at most one per cycle. Each load that arrives is compared, byte by byte, against every store still waiting in the queue. The outcome is one of three:

- **Cache path.** A load that touches none of the queued bytes goes straight to the cache read port in the same cycle.
- **Forwarded.** A load that can be satisfied from a single queued store gets its data from the queue one cycle after it is accepted.
- **Stalled.** Any other load is held back until the conflicting stores have left the queue.

Forwarding is deliberately narrow, so the match logic stays a compare and a select. The newest overlapping store is the only candidate. The load must begin at exactly that store's first byte, and it must be no wider than the store. Every other overlap stalls the load. The queue never assembles a load from several stores and never extracts bytes from the middle of a store. Stalling is cheap to build and always correct, because the cache holds the right bytes once the stores ahead of the load have drained.

Top module: `stfwd_buffer`

## Requirements
- R1: Queued stores are presented on the cache write port oldest first, with address, size and the full 64-bit store data. One leaves per cycle in which `cache_wr_ready` is high. While a presented write is not accepted, it stays valid and unchanged.
- R2: The queue holds DEPTH entries (default 8). With DEPTH entries held, `st_ready` is low, and a store is taken only in a cycle where `st_valid` and `st_ready` are both high.
- R3: A load whose byte range [addr, addr+bytes) touches no queued store is accepted at once, with `ld_ready` high. In the same cycle it appears on `cache_rd_valid`/`cache_rd_addr`/`cache_rd_size` and is not forwarded.
- R4: A load is forwarded when two conditions hold for the newest queued store overlapping it: the load starts at the same address, and the load size is not larger than the store size. One cycle after acceptance, `fwd_valid` is high and `fwd_data` holds the lowest load-size bytes of the store data, with the byte at the start address in bits 7:0 and the upper bits zero.
- R5: A load that starts inside a queued store but not at its first byte is not forwarded. `ld_ready` stays low until no overlapping store remains.
- R6: A load wider than the queued store that starts at the same address is not forwarded, and stalls as in R5.
- R7: A load that overlaps two or more queued stores without meeting R4 stalls until every overlapping store has left the queue. It then goes to the cache as in R3.
- R8: When several queued stores overlap a load, only the newest of them is tested against the R4 rules. A later store to the same bytes therefore supplies the forwarded data.
- R9: A store and a load accepted in the same cycle are ordered with the load first. The load is checked only against stores queued before that cycle.
- R10: After reset the queue is empty: `st_ready` is high, and `cache_wr_valid` and `fwd_valid` are low. Size codes are 0, 1, 2 and 3 for 1, 2, 4 and 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | ADDR_W | Store start byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, start byte in bits 7:0 |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load accepted this cycle (low while stalled) |
| ld_addr | input | ADDR_W | Load start byte address |
| ld_size | input | 2 | Load size code |
| cache_rd_valid | output | 1 | Load issued to the cache this cycle |
| cache_rd_addr | output | ADDR_W | Address of the issued load |
| cache_rd_size | output | 2 | Size code of the issued load |
| fwd_valid | output | 1 | Forwarded load data valid |
| fwd_data | output | 64 | Forwarded data, zero-extended |
| cache_wr_valid | output | 1 | Oldest store presented to the cache |
| cache_wr_ready | input | 1 | Cache takes the presented store |
| cache_wr_addr | output | ADDR_W | Address of the presented store |
| cache_wr_size | output | 2 | Size code of the presented store |
| cache_wr_data | output | 64 | Data of the presented store |

## Verification
The properties assume the load/store unit keeps a stalled load's request steady until `ld_ready` rises. They also assume byte ranges do not wrap past the top of the address space. The bench holds every request until it is taken and draws all addresses from small windows far below that limit. Stall cases are built by freezing `cache_wr_ready` for a few cycles and then releasing it, so every stall reaches its end. The cache write port is never left blocked for good, so every stalled load is eventually accepted.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    // number of bytes covered by a size code
    function automatic logic [3:0] size_bytes(input acc_size_e sz);
        return 4'd1 << sz;
    endfunction

    // keep only the bytes a load of this size receives
    function automatic logic [DATA_W-1:0] trunc_mask(input acc_size_e sz);
        logic [DATA_W-1:0] m;
        case (sz)
            SZ_B1:   m = 64'h0000_0000_0000_00FF;
            SZ_B2:   m = 64'h0000_0000_0000_FFFF;
            SZ_B4:   m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stfwd_queue.sv
module stfwd_queue
    import stfwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [ADDR_W-1:0]                 push_addr,
    input  logic [1:0]                        push_size,
    input  logic [DATA_W-1:0]                 push_data,
    input  logic                              pop,
    output logic                              full,
    output logic                              empty,
    output logic [$clog2(DEPTH)-1:0]          head_ptr,
    output logic [DEPTH-1:0]                  ent_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0]      ent_addr,
    output logic [DEPTH-1:0][1:0]             ent_size,
    output logic [DEPTH-1:0][DATA_W-1:0]      ent_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][1:0]        size;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0]             vld;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.addr[st_q.tail] = push_addr;
            st_d.size[st_q.tail] = push_size;
            st_d.data[st_q.tail] = push_data;
            st_d.vld[st_q.tail]  = 1'b1;
            st_d.tail            = st_q.tail + 1'b1;
        end
        if (pop) begin
            st_d.vld[st_q.head] = 1'b0;
            st_d.head           = st_q.head + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full     = (st_q.cnt == CNT_W'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign head_ptr = st_q.head;
    assign ent_vld  = st_q.vld;
    assign ent_addr = st_q.addr;
    assign ent_size = st_q.size;
    assign ent_data = st_q.data;

    // R2: a store is never written into a full queue
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CNT_W'(DEPTH)));

    // R1: a drain only happens from a non-empty queue
    p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

    // R1: occupancy flags and the entry count move together
    p_count_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vld) == int'(st_q.cnt));

endmodule

// File: rtl/stfwd_match.sv
module stfwd_match
    import stfwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][1:0]        ent_size,
    input  logic [$clog2(DEPTH)-1:0]     head_ptr,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [1:0]                   ld_size,
    output logic                         any_hit,
    output logic [$clog2(DEPTH)-1:0]     sel_idx,
    output logic                         fwd_ok
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] ld_lo, ld_hi;
    logic [DEPTH-1:0] hit;

    assign ld_lo = {1'b0, ld_addr};
    assign ld_hi = ld_lo + EXT_W'(size_bytes(acc_size_e'(ld_size)));

    // per-entry byte-range intersection test
    for (genvar i = 0; i < DEPTH; i++) begin : g_ovl
        logic [EXT_W-1:0] s_lo, s_hi;
        assign s_lo   = {1'b0, ent_addr[i]};
        assign s_hi   = s_lo + EXT_W'(size_bytes(acc_size_e'(ent_size[i])));
        assign hit[i] = ent_vld[i] && (ld_lo < s_hi) && (s_lo < ld_hi);
    end

    // walk oldest to newest; the last hit seen is the newest one
    always_comb begin
        logic [PTR_W-1:0] idx;
        any_hit = 1'b0;
        sel_idx = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_ptr + PTR_W'(k);
            if (hit[idx]) begin
                any_hit = 1'b1;
                sel_idx = idx;
            end
        end
    end

    assign fwd_ok = any_hit
                 && (ent_addr[sel_idx] == ld_addr)
                 && (ld_size <= ent_size[sel_idx]);

endmodule

// File: rtl/stfwd_buffer.sv
module stfwd_buffer
    import stfwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [63:0]       st_data,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    output logic              cache_rd_valid,
    output logic [ADDR_W-1:0] cache_rd_addr,
    output logic [1:0]        cache_rd_size,
    output logic              fwd_valid,
    output logic [63:0]       fwd_data,
    output logic              cache_wr_valid,
    input  logic              cache_wr_ready,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [1:0]        cache_wr_size,
    output logic [63:0]       cache_wr_data
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } fwd_reg_t;

    logic                         q_full, q_empty, q_push, q_pop;
    logic [PTR_W-1:0]             q_head;
    logic [DEPTH-1:0]             q_vld;
    logic [DEPTH-1:0][ADDR_W-1:0] q_addr;
    logic [DEPTH-1:0][1:0]        q_size;
    logic [DEPTH-1:0][DATA_W-1:0] q_data;
    logic                         m_hit, m_fwd;
    logic [PTR_W-1:0]             m_sel;
    logic                         ld_stall;
    fwd_reg_t                     fw_d, fw_q;

    assign st_ready = !q_full;
    assign q_push   = st_valid && st_ready;
    assign q_pop    = cache_wr_valid && cache_wr_ready;

    stfwd_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (st_addr),
        .push_size (st_size),
        .push_data (st_data),
        .pop       (q_pop),
        .full      (q_full),
        .empty     (q_empty),
        .head_ptr  (q_head),
        .ent_vld   (q_vld),
        .ent_addr  (q_addr),
        .ent_size  (q_size),
        .ent_data  (q_data)
    );

    // the load sees the queue as held at the start of the cycle, so a
    // store pushed in the same cycle is younger than the load
    stfwd_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
        .ent_vld  (q_vld),
        .ent_addr (q_addr),
        .ent_size (q_size),
        .head_ptr (q_head),
        .ld_addr  (ld_addr),
        .ld_size  (ld_size),
        .any_hit  (m_hit),
        .sel_idx  (m_sel),
        .fwd_ok   (m_fwd)
    );

    assign ld_stall       = ld_valid && m_hit && !m_fwd;
    assign ld_ready       = !ld_stall;
    assign cache_rd_valid = ld_valid && !m_hit;
    assign cache_rd_addr  = ld_addr;
    assign cache_rd_size  = ld_size;

    assign cache_wr_valid = !q_empty;
    assign cache_wr_addr  = q_addr[q_head];
    assign cache_wr_size  = q_size[q_head];
    assign cache_wr_data  = q_data[q_head];

    always_comb begin
        fw_d     = fw_q;
        fw_d.vld = ld_valid && m_hit && m_fwd;
        if (fw_d.vld) begin
            fw_d.data = q_data[m_sel] & trunc_mask(acc_size_e'(ld_size));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fw_q <= '0;
        else        fw_q <= fw_d;
    end

    assign fwd_valid = fw_q.vld;
    assign fwd_data  = fw_q.data;

    // R1: an unaccepted write stays on the port unchanged
    p_wr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_wr_valid && !cache_wr_ready) |=>
            (cache_wr_valid && $stable(cache_wr_addr) && $stable(cache_wr_size)
             && $stable(cache_wr_data)));

    // R3: a load sent to the cache is never also forwarded
    p_rd_no_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cache_rd_valid |=> !fwd_valid);

    // R4: forwarded data always answers a load taken the cycle before
    p_fwd_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(ld_valid && ld_ready));

    // R7: a held load produces no cache read
    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_ready) |-> !cache_rd_valid);

endmodule

// File: tb/tb_stfwd_buffer.sv
module tb_stfwd_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DEPTH      = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0, ld_valid = 1'b0, cache_wr_ready = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
    logic [1:0]        st_size = '0, ld_size = '0;
    logic [63:0]       st_data = '0;
    logic              st_ready, ld_ready, cache_rd_valid, fwd_valid, cache_wr_valid;
    logic [ADDR_W-1:0] cache_rd_addr, cache_wr_addr;
    logic [1:0]        cache_rd_size, cache_wr_size;
    logic [63:0]       fwd_data, cache_wr_data;

    int  n_checks = 0, n_errors = 0, cyc = 0;
    bit  drain_en = 1'b1, done = 1'b0;

    // reference model state: oldest entry at index 0
    logic [ADDR_W-1:0] m_a[$];
    logic [1:0]        m_s[$];
    logic [63:0]       m_d[$];
    bit                f_cur = 1'b0;
    logic [63:0]       f_dat = '0;

    stfwd_buffer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_size(ld_size),
        .cache_rd_valid(cache_rd_valid), .cache_rd_addr(cache_rd_addr),
        .cache_rd_size(cache_rd_size),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .cache_wr_valid(cache_wr_valid), .cache_wr_ready(cache_wr_ready),
        .cache_wr_addr(cache_wr_addr), .cache_wr_size(cache_wr_size),
        .cache_wr_data(cache_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        cache_wr_ready = drain_en && (cyc % 4 != 3);
        cyc++;
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [63:0] keep_bytes(input logic [63:0] d, input logic [1:0] s);
        int nb = 1 << s;
        logic [63:0] r = '0;
        for (int b = 0; b < nb; b++) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    // newest overlapping entry decides; returns tag of the rule applied
    task automatic classify(input logic [ADDR_W-1:0] a, input logic [1:0] s,
                            output bit hit, output bit fwd, output logic [63:0] d,
                            output string tag);
        longint llo = a, lhi = longint'(a) + (1 << s);
        int nov = 0, young = -1;
        for (int i = m_a.size() - 1; i >= 0; i--) begin
            longint slo = m_a[i];
            longint shi = longint'(m_a[i]) + (1 << m_s[i]);
            if (llo < shi && slo < lhi) begin
                nov++;
                if (young < 0) young = i;
            end
        end
        hit = (nov > 0);
        fwd = 1'b0;
        d   = '0;
        tag = "R3";
        if (hit) begin
            fwd = (m_a[young] == a) && (s <= m_s[young]);
            if (fwd) d = keep_bytes(m_d[young], s);
            if (nov > 1)               tag = fwd ? "R8" : "R7";
            else if (fwd)              tag = "R4";
            else if (m_a[young] != a)  tag = "R5";
            else                       tag = "R6";
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_hit, e_fwd, e_wr, e_st, e_stall;
            logic [63:0] e_data;
            string tag;
            classify(ld_addr, ld_size, e_hit, e_fwd, e_data, tag);
            e_wr    = (m_a.size() > 0);
            e_st    = (m_a.size() < DEPTH);
            e_stall = ld_valid && e_hit && !e_fwd;
            chk("R2", "st_ready", st_ready, e_st);
            chk("R1", "cache_wr_valid", cache_wr_valid, e_wr);
            if (e_wr) begin
                chk("R1", "cache_wr_addr", cache_wr_addr, m_a[0]);
                chk("R1", "cache_wr_size", cache_wr_size, m_s[0]);
                chk("R1", "cache_wr_data", cache_wr_data, m_d[0]);
            end
            chk(tag, "ld_ready", ld_ready, !e_stall);
            chk(tag, "cache_rd_valid", cache_rd_valid, ld_valid && !e_hit);
            if (ld_valid && !e_hit) begin
                chk("R3", "cache_rd_addr", cache_rd_addr, ld_addr);
                chk("R3", "cache_rd_size", cache_rd_size, ld_size);
            end
            chk("R4", "fwd_valid", fwd_valid, f_cur);
            if (f_cur) chk("R4", "fwd_data", fwd_data, f_dat);
            // advance model
            f_cur = ld_valid && e_hit && e_fwd;
            f_dat = e_data;
            if (e_wr && cache_wr_ready) begin
                void'(m_a.pop_front()); void'(m_s.pop_front()); void'(m_d.pop_front());
            end
            if (st_valid && e_st) begin
                m_a.push_back(st_addr); m_s.push_back(st_size); m_d.push_back(st_data);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [1:0] s, input logic [63:0] d);
        st_valid = 1'b1; st_addr = a; st_size = s; st_data = d;
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] a, input logic [1:0] s);
        ld_valid = 1'b1; ld_addr = a; ld_size = s;
        do @(negedge clk); while (!ld_ready);
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic wait_empty();
        do @(negedge clk); while (cache_wr_valid);
        @(posedge clk); #1;
    endtask

    task automatic stall_then_release(input logic [31:0] a, input logic [1:0] s);
        fork
            do_load(a, s);
            begin idle(5); drain_en = 1'b1; end
        join
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "st_ready", st_ready, 1'b1);
        chk("R10", "cache_wr_valid", cache_wr_valid, 1'b0);
        chk("R10", "fwd_valid", fwd_valid, 1'b0);
        chk("R10", "ld_ready", ld_ready, 1'b1);
        @(posedge clk); #1;

        // R4: exact and truncated forwarding
        drain_en = 1'b0; idle(1);
        do_store(32'h100, 2'd3, 64'h1122_3344_5566_7788);
        do_load(32'h100, 2'd3);
        do_load(32'h100, 2'd1);
        do_load(32'h100, 2'd0);
        // R3: unrelated load goes to the cache
        do_load(32'h180, 2'd3);
        // R5: upper half of an 8-byte store
        stall_then_release(32'h104, 2'd2);
        wait_empty();

        // R6: wider load at same start
        drain_en = 1'b0; idle(1);
        do_store(32'h200, 2'd2, 64'hAAAA_BBBB_CCCC_DDDD);
        stall_then_release(32'h200, 2'd3);
        wait_empty();

        // R7: straddles two adjacent stores
        drain_en = 1'b0; idle(1);
        do_store(32'h300, 2'd3, 64'h0101_0202_0303_0404);
        do_store(32'h308, 2'd3, 64'h0505_0606_0707_0808);
        stall_then_release(32'h304, 2'd3);
        wait_empty();

        // R8: newest store supplies data, or decides the stall
        drain_en = 1'b0; idle(1);
        do_store(32'h400, 2'd2, 64'h0000_0000_DEAD_BEEF);
        do_store(32'h400, 2'd3, 64'hCAFE_F00D_1234_5678);
        do_store(32'h600, 2'd3, 64'h1111_1111_1111_1111);
        do_store(32'h600, 2'd3, 64'h2222_2222_2222_2222);
        do_load(32'h400, 2'd3);
        do_load(32'h600, 2'd3);
        do_store(32'h500, 2'd3, 64'h9999_8888_7777_6666);
        do_store(32'h500, 2'd1, 64'h0000_0000_0000_4444);
        stall_then_release(32'h500, 2'd2);
        wait_empty();

        // R2: fill the queue, ninth store waits
        drain_en = 1'b0; idle(1);
        for (int i = 0; i < DEPTH; i++) do_store(32'h900 + 8*i, 2'd3, 64'(i + 1));
        fork
            do_store(32'h9F0, 2'd3, 64'h99);
            begin idle(4); drain_en = 1'b1; end
        join
        wait_empty();

        // R9: same-cycle store and load to the same bytes
        st_valid = 1'b1; st_addr = 32'h700; st_size = 2'd3; st_data = 64'h7777;
        ld_valid = 1'b1; ld_addr = 32'h700; ld_size = 2'd3;
        @(negedge clk);
        chk("R9", "cache_rd_valid", cache_rd_valid, 1'b1);
        chk("R9", "ld_ready", ld_ready, 1'b1);
        @(posedge clk); #1;
        st_valid = 1'b0; ld_valid = 1'b0;
        @(negedge clk);
        chk("R9", "fwd_valid", fwd_valid, 1'b0);
        @(posedge clk); #1;
        wait_empty();

        // mixed traffic over a small window
        for (int n = 0; n < 600; n++) begin
            logic [1:0]  s = 2'($urandom % 4);
            logic [31:0] a = (32'h800 + ($urandom % 32)) & ~((32'd1 << s) - 1);
            if ($urandom % 3 == 0) do_store(a, s, {$urandom, $urandom});
            else                   do_load(a, s);
            if ($urandom % 5 == 0) idle(1);
        end
        wait_empty();
        idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule